// File: doc/BRIEF.md
# Dual-Pairset Detection Sequencer

This controller orders the detection, classification and power-up steps of a power sourcing port that feeds a load over two independent pairsets, called primary and secondary. Each pairset runs its own step machine. The controller issues single-cycle start strobes to the external measurement and switching blocks and waits for their done flags. A 2-bit sequence mode and a signature-type input decide how tightly the secondary pairset is tied to the progress of the primary pairset.

Detection on the secondary pairset is held back by a small gate machine. The gate has three states: entry, idle and open. Depending on the mode, the gate opens at once, when primary detection starts, when primary detection has given a valid result, or when the primary pairset reports that it is powered. When primary detection ends for any reason (a valid result, a failed result or a timeout), the gate leaves its entry state. A failed primary attempt therefore never leaves the secondary stuck.

Each pairset performs detection once. It then holds its result until the host asks for power, and only then starts classification and power-up. A timeout counter bounds each detection window. Losing primary power sends everything back to the start.

Top module: `pdseq_ctrl`

## Requirements
- R1: While `rst` is high, all seven start strobes are low, and both pairset machines return to their idle state.
- R2: In mode 0 the primary pairset pulses `cc_start` first and starts detection only after `cc_done`. `cc_start` is never pulsed in any other mode.
- R3: Secondary detection starts without waiting for a primary result in two cases. In mode 1 it starts independently. In mode 0 with `dual_sig`=1 it starts once primary detection has started, so both detections share one window.
- R4: In mode 2, and in mode 0 with `dual_sig`=0, `det_start_sec` is pulsed only after primary detection has returned a valid result.
- R5: In mode 3, `det_start_sec` is pulsed only while the primary pairset is in its powered state. That state is reached after `pwr_start_pri` and `pri_powered`=1.
- R6: A failed (`det_ok`=0) or timed-out primary detection releases the secondary gate from its entry state. The primary then retries, and after a later valid primary result the secondary detection starts.
- R7: Suppose a detection window passes DET_CYC cycles with no `det_done`. The attempt is then a failure, and the next `det_start` of that pairset follows the previous one by exactly DET_CYC+2 cycles.
- R8: Once a pairset holds a valid detection, it pulses no further strobe until the host command, so detection and classification do not repeat while the port waits.
- R9: A pulse on `host_pwr_on` is remembered. A pairset pulses its classification start only when it holds a valid detection and the command has been seen, whether the command came before or after that detection.
- R10: A pairset pulses its power start once, after its classification done flag. Every strobe is high for exactly one cycle.
- R11: If `pri_powered` falls while the primary pairset is powered, then in the next cycle all strobes are low, both machines restart from idle and the host command is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seq_mode | input | 2 | Ordering mode 0..3 |
| dual_sig | input | 1 | 1 when the load shows a separate signature per pairset |
| host_pwr_on | input | 1 | Host power-on command pulse |
| cc_done | input | 1 | Connection check finished |
| det_done_pri | input | 1 | Primary detection finished |
| det_ok_pri | input | 1 | Primary detection result valid (with done) |
| det_done_sec | input | 1 | Secondary detection finished |
| det_ok_sec | input | 1 | Secondary detection result valid (with done) |
| cls_done_pri | input | 1 | Primary classification finished |
| cls_done_sec | input | 1 | Secondary classification finished |
| pri_powered | input | 1 | Primary pairset power is up |
| cc_start | output | 1 | Start connection check |
| det_start_pri | output | 1 | Start primary detection |
| det_start_sec | output | 1 | Start secondary detection |
| cls_start_pri | output | 1 | Start primary classification |
| cls_start_sec | output | 1 | Start secondary classification |
| pwr_start_pri | output | 1 | Request primary power-up |
| pwr_start_sec | output | 1 | Request secondary power-up |

## Verification
The bench runs each of the four modes with its own stimulus pattern. In each case it holds back the primary responses, so that an early secondary detection strobe appears as an unexpected event. Mode 0 is tried with both signature types, which separates parallel from staggered gating. Mode 2 runs a primary timeout and then a failed primary result, which separates a working entry escape from a stall and measures the window length. Mode 3 holds the secondary back across the whole primary power-up. Mode 1 covers the host command arriving after both detections, a loss of primary power, and the restart that follows it.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

   typedef enum logic [3:0] {
      PS_IDLE, PS_CC_GO, PS_CC, PS_DET_GO, PS_DET, PS_VALID,
      PS_CLS_GO, PS_CLS, PS_PWR_GO, PS_PWR_WAIT, PS_ON
   } ps_state_t;

   typedef enum logic [1:0] {GT_ENTRY, GT_IDLE, GT_OPEN} gate_state_t;

   localparam logic [1:0] MODE_CC   = 2'd0;
   localparam logic [1:0] MODE_FREE = 2'd1;
   localparam logic [1:0] MODE_STAG = 2'd2;
   localparam logic [1:0] MODE_PWRD = 2'd3;

endpackage

// File: rtl/pdseq_det_timer.sv
module pdseq_det_timer #(
   parameter int LIMIT = 32
) (
   input  logic clk,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!run) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pdseq_pairset.sv
module pdseq_pairset
   import pdseq_pkg::*;
#(
   parameter int DET_CYC = 32
) (
   input  logic      clk,
   input  logic      clear,
   input  logic      go,
   input  logic      use_cc,
   input  logic      allow_cls,
   input  logic      cc_done,
   input  logic      det_done,
   input  logic      det_ok,
   input  logic      cls_done,
   input  logic      pwr_fb,
   output ps_state_t state_o
);
   ps_state_t st_q, st_d;
   logic      tmo;

   pdseq_det_timer #(.LIMIT(DET_CYC)) u_tmr (
      .clk     (clk),
      .run     (st_q == PS_DET),
      .expired (tmo)
   );

   always_comb begin
      st_d = st_q;
      case (st_q)
         PS_IDLE:     if (go) st_d = use_cc ? PS_CC_GO : PS_DET_GO;
         PS_CC_GO:    st_d = PS_CC;
         PS_CC:       if (cc_done) st_d = PS_DET_GO;
         PS_DET_GO:   st_d = PS_DET;
         PS_DET: begin
            if (det_done)  st_d = det_ok ? PS_VALID : PS_IDLE;
            else if (tmo)  st_d = PS_IDLE;
         end
         PS_VALID:    if (allow_cls) st_d = PS_CLS_GO;
         PS_CLS_GO:   st_d = PS_CLS;
         PS_CLS:      if (cls_done) st_d = PS_PWR_GO;
         PS_PWR_GO:   st_d = PS_PWR_WAIT;
         PS_PWR_WAIT: if (pwr_fb) st_d = PS_ON;
         PS_ON:       st_d = PS_ON;
         default:     st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (clear) st_q <= PS_IDLE;
      else       st_q <= st_d;
   end

   assign state_o = st_q;
endmodule

// File: rtl/pdseq_sec_gate.sv
module pdseq_sec_gate
   import pdseq_pkg::*;
(
   input  logic       clk,
   input  logic       clear,
   input  logic [1:0] seq_mode,
   input  logic       dual_sig,
   input  ps_state_t  pri_st,
   output logic       go
);
   gate_state_t g_q, g_d;
   logic        was_det_q;
   logic        pri_det, pri_in_det, pri_past, det_over;

   assign pri_det    = (pri_st == PS_DET);
   assign pri_in_det = pri_det || (pri_st == PS_DET_GO);
   assign pri_past   = pri_st inside {PS_VALID, PS_CLS_GO, PS_CLS,
                                      PS_PWR_GO, PS_PWR_WAIT, PS_ON};
   assign det_over   = was_det_q && !pri_det;

   always_comb begin
      g_d = g_q;
      case (g_q)
         GT_ENTRY: begin
            if (seq_mode == MODE_FREE)                    g_d = GT_OPEN;
            else if (seq_mode == MODE_CC && dual_sig) begin
               if (pri_in_det)                            g_d = GT_OPEN;
            end
            else if (det_over)                            g_d = GT_IDLE;
         end
         GT_IDLE: begin
            if (seq_mode == MODE_PWRD) begin
               if (pri_st == PS_ON) g_d = GT_OPEN;
            end
            else if (pri_past)      g_d = GT_OPEN;
         end
         GT_OPEN:  g_d = GT_OPEN;
         default:  g_d = GT_ENTRY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (clear) begin
         g_q       <= GT_ENTRY;
         was_det_q <= 1'b0;
      end else begin
         g_q       <= g_d;
         was_det_q <= pri_det;
      end
   end

   assign go = (g_q == GT_OPEN);
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
   import pdseq_pkg::*;
#(
   parameter int DET_CYC = 32
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] seq_mode,
   input  logic       dual_sig,
   input  logic       host_pwr_on,
   input  logic       cc_done,
   input  logic       det_done_pri,
   input  logic       det_ok_pri,
   input  logic       det_done_sec,
   input  logic       det_ok_sec,
   input  logic       cls_done_pri,
   input  logic       cls_done_sec,
   input  logic       pri_powered,
   output logic       cc_start,
   output logic       det_start_pri,
   output logic       det_start_sec,
   output logic       cls_start_pri,
   output logic       cls_start_sec,
   output logic       pwr_start_pri,
   output logic       pwr_start_sec
);
   localparam int NPAIR = 2;

   if (DET_CYC < 2) begin : g_bad_det_cyc
      $error("pdseq_ctrl: DET_CYC must be at least 2");
   end

   ps_state_t        st_q [NPAIR];
   ps_state_t        pri_st, sec_st;
   logic             lost, kill, host_req, sec_go;
   logic [NPAIR-1:0] go_v, usecc_v, ccd_v, dd_v, dok_v, cd_v, fb_v;

   assign dd_v  = {det_done_sec, det_done_pri};
   assign dok_v = {det_ok_sec,   det_ok_pri};
   assign cd_v  = {cls_done_sec, cls_done_pri};

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      if (p == 0) begin : g_pri
         assign go_v[p]    = 1'b1;
         assign usecc_v[p] = (seq_mode == MODE_CC);
         assign ccd_v[p]   = cc_done;
         assign fb_v[p]    = pri_powered;
      end else begin : g_sec
         assign go_v[p]    = sec_go;
         assign usecc_v[p] = 1'b0;
         assign ccd_v[p]   = 1'b0;
         assign fb_v[p]    = 1'b1;
      end

      pdseq_pairset #(.DET_CYC(DET_CYC)) u_ps (
         .clk       (clk),
         .clear     (kill),
         .go        (go_v[p]),
         .use_cc    (usecc_v[p]),
         .allow_cls (host_req),
         .cc_done   (ccd_v[p]),
         .det_done  (dd_v[p]),
         .det_ok    (dok_v[p]),
         .cls_done  (cd_v[p]),
         .pwr_fb    (fb_v[p]),
         .state_o   (st_q[p])
      );
   end

   assign pri_st = st_q[0];
   assign sec_st = st_q[1];

   pdseq_sec_gate u_gate (
      .clk      (clk),
      .clear    (kill),
      .seq_mode (seq_mode),
      .dual_sig (dual_sig),
      .pri_st   (pri_st),
      .go       (sec_go)
   );

   assign lost = (pri_st == PS_ON) && !pri_powered;
   assign kill = rst || lost;

   always_ff @(posedge clk) begin
      if (kill)             host_req <= 1'b0;
      else if (host_pwr_on) host_req <= 1'b1;
   end

   assign cc_start      = (pri_st == PS_CC_GO);
   assign det_start_pri = (pri_st == PS_DET_GO);
   assign det_start_sec = (sec_st == PS_DET_GO);
   assign cls_start_pri = (pri_st == PS_CLS_GO);
   assign cls_start_sec = (sec_st == PS_CLS_GO);
   assign pwr_start_pri = (pri_st == PS_PWR_GO);
   assign pwr_start_sec = (sec_st == PS_PWR_GO);
endmodule

// File: rtl/pdseq_checks.sv
module pdseq_checks
   import pdseq_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic [1:0] seq_mode,
   input logic       pri_powered,
   input logic       cls_done_pri,
   input logic       host_req,
   input ps_state_t  pri_st,
   input logic [6:0] strobes
);
   // strobes: [6] cc, [5] det pri, [4] det sec, [3] cls pri, [2] cls sec, [1] pwr pri, [0] pwr sec

   a_r2_cc_only_mode0: assert property (@(posedge clk) disable iff (rst)
      strobes[6] |-> (seq_mode == MODE_CC));

   a_r4_stag_after_valid: assert property (@(posedge clk) disable iff (rst)
      (seq_mode == MODE_STAG && strobes[4]) |->
         (pri_st inside {PS_VALID, PS_CLS_GO, PS_CLS, PS_PWR_GO, PS_PWR_WAIT, PS_ON}));

   a_r5_sec_needs_power: assert property (@(posedge clk) disable iff (rst)
      (seq_mode == MODE_PWRD && strobes[4]) |-> (pri_st == PS_ON));

   a_r9_cls_needs_host: assert property (@(posedge clk) disable iff (rst)
      (strobes[3] || strobes[2]) |-> host_req);

   a_r10_pwr_after_cls: assert property (@(posedge clk) disable iff (rst)
      strobes[1] |-> $past(cls_done_pri));

   a_r11_loss_clears: assert property (@(posedge clk) disable iff (rst)
      (pri_st == PS_ON && !pri_powered) |=> (strobes == 7'd0 && !host_req));
endmodule

bind pdseq_ctrl pdseq_checks u_chk (
   .clk          (clk),
   .rst          (rst),
   .seq_mode     (seq_mode),
   .pri_powered  (pri_powered),
   .cls_done_pri (cls_done_pri),
   .host_req     (host_req),
   .pri_st       (pri_st),
   .strobes      ({cc_start, det_start_pri, det_start_sec, cls_start_pri,
                   cls_start_sec, pwr_start_pri, pwr_start_sec})
);

// File: tb/pdseq_ctrl_test.sv
module pdseq_ctrl_test;
   localparam int DET_CYC = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0] seq_mode = 2'd0;
   logic dual_sig = 1'b0, host_pwr_on = 1'b0, cc_done = 1'b0;
   logic det_done_pri = 1'b0, det_ok_pri = 1'b0, det_done_sec = 1'b0, det_ok_sec = 1'b0;
   logic cls_done_pri = 1'b0, cls_done_sec = 1'b0, pri_powered = 1'b0;
   logic cc_start, det_start_pri, det_start_sec, cls_start_pri, cls_start_sec;
   logic pwr_start_pri, pwr_start_sec;
   logic [6:0] strobes;

   typedef struct {
      logic [6:0] v;
      string      tag;
   } exp_t;

   exp_t       exp_q[$];
   int         n_cmp = 0, n_bad = 0, cyc_n = 0;
   int         dp_last = 0, dp_prev = 0;
   logic [6:0] seen = '0;

   always #2.5ns clk = ~clk;

   pdseq_ctrl #(.DET_CYC(DET_CYC)) uut (
      .clk(clk), .rst(rst), .seq_mode(seq_mode), .dual_sig(dual_sig),
      .host_pwr_on(host_pwr_on), .cc_done(cc_done),
      .det_done_pri(det_done_pri), .det_ok_pri(det_ok_pri),
      .det_done_sec(det_done_sec), .det_ok_sec(det_ok_sec),
      .cls_done_pri(cls_done_pri), .cls_done_sec(cls_done_sec),
      .pri_powered(pri_powered), .cc_start(cc_start),
      .det_start_pri(det_start_pri), .det_start_sec(det_start_sec),
      .cls_start_pri(cls_start_pri), .cls_start_sec(cls_start_sec),
      .pwr_start_pri(pwr_start_pri), .pwr_start_sec(pwr_start_sec)
   );

   assign strobes = {cc_start, det_start_pri, det_start_sec, cls_start_pri,
                     cls_start_sec, pwr_start_pri, pwr_start_sec};

   always @(posedge clk) cyc_n <= cyc_n + 1;

   // monitor: every cycle with a strobe is compared with the next expected item
   always @(negedge clk) begin
      if (!rst && strobes != 7'd0) begin
         n_cmp++;
         seen = seen | strobes;
         if (strobes[5]) begin
            dp_prev = dp_last;
            dp_last = cyc_n;
         end
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R8 unexpected strobe: got %b expected none", strobes);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.v !== strobes) begin
               n_bad++;
               $display("FAIL %s: got %b expected %b", e.tag, strobes, e.v);
            end
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [6:0] v, input string tag);
      exp_t e;
      e.v = v;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic wait_seen(input int idx);
      while (!seen[idx]) @(negedge clk);
      seen[idx] = 1'b0;
   endtask

   // mask: 0 cc_done, 1 det pri, 2 det sec, 3 cls pri, 4 cls sec, 5 host
   task automatic pulse(input logic [5:0] m, input bit ok);
      @(negedge clk);
      cc_done = m[0]; det_done_pri = m[1]; det_ok_pri = m[1] & ok;
      det_done_sec = m[2]; det_ok_sec = m[2] & ok;
      cls_done_pri = m[3]; cls_done_sec = m[4]; host_pwr_on = m[5];
      @(negedge clk);
      cc_done = 0; det_done_pri = 0; det_ok_pri = 0; det_done_sec = 0;
      det_ok_sec = 0; cls_done_pri = 0; cls_done_sec = 0; host_pwr_on = 0;
   endtask

   task automatic start(input logic [1:0] m, input bit ds);
      @(negedge clk);
      rst = 1'b1;
      pri_powered = 1'b0;
      seq_mode = m;
      dual_sig = ds;
      cyc(3);
      check(strobes == 7'd0, "R1 strobes low in reset", int'(strobes), 0);
      exp_q.delete();
      seen = '0;
   endtask

   task automatic release_rst();
      rst = 1'b0;
   endtask

   task automatic drained(input string tag);
      check(exp_q.size() == 0, tag, exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // mode 1 dual: free ordering, host later, power loss
      start(2'd1, 1'b1);
      push(7'b0100000, "R3 mode1 pri det");
      push(7'b0010000, "R3 mode1 sec det without pri result");
      release_rst();
      wait_seen(5); wait_seen(4);
      drained("R3 both detections started");
      pulse(6'b000110, 1'b1);
      cyc(40);                                  // R8: nothing may appear here
      drained("R8 idle while waiting for host");
      push(7'b0001100, "R9 cls both after host");
      pulse(6'b100000, 1'b0);
      wait_seen(3);
      push(7'b0000011, "R10 pwr both after cls");
      pulse(6'b011000, 1'b0);
      wait_seen(1);
      @(negedge clk) pri_powered = 1'b1;
      cyc(3);
      push(7'b0100000, "R11 restart pri det after loss");
      push(7'b0010000, "R11 restart sec det after loss");
      @(negedge clk) pri_powered = 1'b0;
      wait_seen(5); wait_seen(4);
      pulse(6'b000110, 1'b1);
      cyc(30);                                  // R11: host command forgotten
      drained("R11 no cls without new host command");

      // mode 0 single: connection check then staggered
      start(2'd0, 1'b0);
      push(7'b1000000, "R2 cc first");
      release_rst();
      wait_seen(6);
      push(7'b0100000, "R2 det after cc_done");
      cyc(5);
      pulse(6'b000001, 1'b0);
      wait_seen(5);
      cyc(10);                                  // R4: secondary must wait
      push(7'b0010000, "R4 sec after pri valid");
      pulse(6'b000010, 1'b1);
      wait_seen(4);
      drained("R4 staggered order");

      // mode 2 dual: timeout, failure, then success
      start(2'd2, 1'b1);
      push(7'b0100000, "R7 first pri det");
      release_rst();
      wait_seen(5);
      push(7'b0100000, "R7 retry after timeout");
      wait_seen(5);
      check(dp_last - dp_prev == DET_CYC + 2, "R7 retry spacing",
            dp_last - dp_prev, DET_CYC + 2);
      push(7'b0100000, "R6 retry after failed result");
      pulse(6'b000010, 1'b0);
      wait_seen(5);
      push(7'b0010000, "R6 sec starts, gate not stuck");
      pulse(6'b000010, 1'b1);
      wait_seen(4);
      drained("R6 escape complete");

      // mode 3 dual: secondary held until primary powered; host before sec
      start(2'd3, 1'b1);
      push(7'b0100000, "R5 pri det");
      release_rst();
      wait_seen(5);
      pulse(6'b000010, 1'b1);
      cyc(10);
      push(7'b0001000, "R9 pri cls after host");
      pulse(6'b100000, 1'b0);
      wait_seen(3);
      push(7'b0000010, "R10 pri pwr after cls");
      pulse(6'b001000, 1'b0);
      wait_seen(1);
      cyc(10);                                  // R5: still no secondary
      push(7'b0010000, "R5 sec det after pri powered");
      @(negedge clk) pri_powered = 1'b1;
      wait_seen(4);
      push(7'b0000100, "R9 sec cls with latched host");
      pulse(6'b000100, 1'b1);
      wait_seen(2);
      push(7'b0000001, "R10 sec pwr after cls");
      pulse(6'b010000, 1'b0);
      wait_seen(0);
      cyc(5);
      drained("R5 full sequence");

      // mode 0 dual: parallel detection
      start(2'd0, 1'b1);
      push(7'b1000000, "R2 cc first parallel");
      release_rst();
      wait_seen(6);
      push(7'b0100000, "R3 pri det parallel");
      push(7'b0010000, "R3 sec det parallel");
      pulse(6'b000001, 1'b0);
      wait_seen(5); wait_seen(4);
      pulse(6'b000110, 1'b1);
      cyc(60);
      drained("R8 no repeat while waiting");

      start(2'd0, 1'b0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule